// File: doc/BRIEF.md
# DMA Bus-Error Retry Controller

This block sits between a DMA engine and the system bus. It decides what happens when a bus cycle fails. The engine hands it one bus cycle at a time: an address, a size code, a direction and the index of the buffer the cycle belongs to. The controller drives that cycle onto the bus and waits for the completion handshake. If the bus reports an error and retry budget is left, the controller reissues the same cycle and spends one unit of budget. If no budget is left, it escalates: it raises an interrupt and blocks further cycles to the buffer in error.

The retry budget is an 8-bit register that the host can read and write. The budget is shared by all cycles and is not refilled per transfer. Every retry consumes one unit, and when the budget is empty the next error escalates. After taking the interrupt, the host acknowledges it, which lifts the interrupt and every buffer block. The host may then load a new budget.

Top module: `rtry_ctrl`

## Requirements
- R1: After reset the budget reads 0x00, the interrupt and all suspend flags are low, and no bus cycle or retry strobe is driven.
- R2: A host write strobe loads the budget, and the read port shows the written value from the next cycle on.
- R3: A failed cycle with a non-zero budget lowers the budget by one. The bus request then drops for exactly one cycle, and the same address, size and direction are reissued with the retry strobe high in the first reissue cycle.
- R4: A failed cycle with a zero budget pulses the failure output in the completion cycle. From the next cycle on, the interrupt is high and the suspend flag of that cycle's buffer (bit index equal to the buffer number) is high, and the cycle is not reissued.
- R5: A successful cycle pulses the success output in its completion cycle and leaves the budget unchanged.
- R6: A host write in the same cycle as a retry decrement wins: the budget takes the written value and the retry still happens.
- R7: While a buffer's suspend flag is high, the request-ready output is low for requests naming that buffer, and it stays high for requests naming other buffers while the controller is idle.
- R8: A one-cycle acknowledge pulse clears the interrupt and all suspend flags from the next cycle on.
- R9: A completion or error indication with no cycle outstanding changes neither the budget nor the interrupt, and produces no success or failure pulse.
- R10: The budget carries across cycles. With budget b, a cycle that fails e times in a row succeeds after e retries when e <= b, and escalates after b retries when e > b. The budget is then b - min(e, b).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Host write strobe for the budget register |
| cfg_wdata | input | CW | Host write data |
| cfg_rdata | output | CW | Current budget |
| req_valid | input | 1 | DMA engine offers a bus cycle |
| req_ready | output | 1 | Cycle accepted this clock |
| req_addr | input | AW | Cycle address |
| req_size | input | SW | Cycle size code |
| req_dir | input | 1 | Cycle direction (1 = write) |
| req_buf | input | BW | Buffer the cycle belongs to |
| bus_req | output | 1 | Bus cycle request |
| bus_addr | output | AW | Bus cycle address |
| bus_size | output | SW | Bus cycle size code |
| bus_dir | output | 1 | Bus cycle direction |
| bus_done | input | 1 | Bus cycle completed |
| bus_err | input | 1 | Completion carried an error (valid with bus_done) |
| retry_stb | output | 1 | High in the first cycle of a reissued bus cycle |
| xfer_ok | output | 1 | Cycle completed without error |
| xfer_fail | output | 1 | Cycle escalated |
| irq | output | 1 | Interrupt to the host |
| irq_ack | input | 1 | Host acknowledge pulse |
| susp | output | NBUF | Per-buffer suspend flags |

## Verification
A wrong budget stays invisible until the next bus error. It then shows as a retry where an escalation was due, or the reverse, within one cycle of that error. The read port exposes it one cycle after any decrement. A wrong sequencer state shows at once on the bus: a missing or doubled idle gap, a reissue with a changed address or size, or a retry strobe in the wrong cycle. The bench therefore sweeps every combination of small budget and consecutive-error count. After each error it checks the gap, the reissued fields, the strobe, and the budget read back in the gap cycle. A stuck or lost suspend flag shows on the ready output for the next request to that buffer.

// File: rtl/rtry_pkg.sv
package rtry_pkg;

    // Sequencer states for one bus cycle in flight.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_GAP   = 2'd2
    } seq_st_e;

    // Outcome of a bus completion, decided in the completion cycle.
    typedef enum logic [1:0] {
        VD_NONE  = 2'd0,
        VD_OK    = 2'd1,
        VD_RETRY = 2'd2,
        VD_ESCAL = 2'd3
    } verdict_e;

    // Classify a completion: only an outstanding cycle can be judged.
    function automatic verdict_e judge(input logic live, input logic done,
                                       input logic err, input logic has_budget);
        if (!live || !done)  return VD_NONE;
        if (!err)            return VD_OK;
        if (has_budget)      return VD_RETRY;
        return VD_ESCAL;
    endfunction

endpackage

// File: rtl/rtry_budget.sv
module rtry_budget #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_data,
    input  logic          dec,
    output logic [CW-1:0] cnt,
    output logic          nz
);

    logic [CW-1:0] cnt_q;

    // Host write wins over a retry decrement in the same cycle.
    always_ff @(posedge clk) begin
        if (rst)        cnt_q <= '0;
        else if (wr_en) cnt_q <= wr_data;
        else if (dec)   cnt_q <= cnt_q - CW'(1);
    end

    assign cnt = cnt_q;
    assign nz  = |cnt_q;

    // R3
    dec_nz_chk: assert property (@(posedge clk) disable iff (rst)
        dec |-> (cnt_q != '0));

    // R3
    dec_step_chk: assert property (@(posedge clk) disable iff (rst)
        (dec && !wr_en) |=> (cnt_q == $past(cnt_q) - CW'(1)));

    // R6
    wr_prio_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (cnt_q == $past(wr_data)));

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !dec) |=> $stable(cnt_q));

endmodule

// File: rtl/rtry_seq.sv
module rtry_seq
    import rtry_pkg::*;
#(
    parameter int AW   = 32,
    parameter int SW   = 2,
    parameter int NBUF = 2,
    parameter int BW   = 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic [AW-1:0]   req_addr,
    input  logic [SW-1:0]   req_size,
    input  logic            req_dir,
    input  logic [BW-1:0]   req_buf,
    output logic            req_ready,
    input  logic [NBUF-1:0] susp,
    input  logic            has_budget,
    input  logic            bus_done,
    input  logic            bus_err,
    output logic            bus_req,
    output logic [AW-1:0]   bus_addr,
    output logic [SW-1:0]   bus_size,
    output logic            bus_dir,
    output logic            retry_stb,
    output verdict_e        verdict,
    output logic [BW-1:0]   cur_buf
);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [SW-1:0] size;
        logic          dir;
        logic [BW-1:0] bsel;
    } cyc_t;

    seq_st_e  st_q;
    cyc_t     hold_q;
    logic     rs_q;
    verdict_e vd;

    assign vd        = judge(st_q == ST_ISSUE, bus_done, bus_err, has_budget);
    assign req_ready = (st_q == ST_IDLE) && !susp[req_buf];

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            hold_q <= '0;
            rs_q   <= 1'b0;
        end else begin
            rs_q <= (st_q == ST_GAP);
            unique case (st_q)
                ST_IDLE: begin
                    if (req_valid && req_ready) begin
                        hold_q <= '{addr: req_addr, size: req_size,
                                    dir: req_dir, bsel: req_buf};
                        st_q   <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    unique case (vd)
                        VD_OK, VD_ESCAL: st_q <= ST_IDLE;
                        VD_RETRY:        st_q <= ST_GAP;
                        default:         st_q <= ST_ISSUE;
                    endcase
                end
                ST_GAP:  st_q <= ST_ISSUE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign bus_req   = (st_q == ST_ISSUE);
    assign bus_addr  = hold_q.addr;
    assign bus_size  = hold_q.size;
    assign bus_dir   = hold_q.dir;
    assign retry_stb = rs_q;
    assign verdict   = vd;
    assign cur_buf   = hold_q.bsel;

    // R3
    gap_len_chk: assert property (@(posedge clk) disable iff (rst)
        (vd == VD_RETRY) |=> (!bus_req ##1 bus_req));

    // R3
    retry_same_chk: assert property (@(posedge clk) disable iff (rst)
        retry_stb |-> (bus_req && bus_addr == $past(bus_addr, 2)
                       && bus_size == $past(bus_size, 2)
                       && bus_dir == $past(bus_dir, 2)));

    // R3
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_done) |=> (bus_req && $stable(bus_addr) && $stable(bus_size)));

    // R7
    susp_block_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && susp[req_buf]) |=> !(bus_req && !$past(bus_req)));

endmodule

// File: rtl/rtry_escal.sv
module rtry_escal #(
    parameter int NBUF = 2,
    parameter int BW   = 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            esc,
    input  logic [BW-1:0]   esc_buf,
    input  logic            ack,
    output logic            irq,
    output logic [NBUF-1:0] susp
);

    logic            irq_q;
    logic [NBUF-1:0] susp_q;

    // A new escalation sets its flag even when it meets an acknowledge.
    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= esc | (irq_q & ~ack);
    end

    for (genvar i = 0; i < NBUF; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) susp_q[i] <= 1'b0;
            else     susp_q[i] <= (esc && esc_buf == BW'(i)) | (susp_q[i] & ~ack);
        end
    end

    assign irq  = irq_q;
    assign susp = susp_q;

    // R4
    esc_set_chk: assert property (@(posedge clk) disable iff (rst)
        esc |=> (irq_q && susp_q[$past(esc_buf)]));

    // R8
    ack_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && !esc) |=> (!irq_q && susp_q == '0));

    // R4
    irq_susp_chk: assert property (@(posedge clk) disable iff (rst)
        irq_q == (susp_q != '0));

endmodule

// File: rtl/rtry_ctrl.sv
module rtry_ctrl
    import rtry_pkg::*;
#(
    parameter int  AW   = 32,
    parameter int  SW   = 2,
    parameter int  CW   = 8,
    parameter int  NBUF = 2,
    localparam int BW   = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_wr,
    input  logic [CW-1:0]   cfg_wdata,
    output logic [CW-1:0]   cfg_rdata,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [AW-1:0]   req_addr,
    input  logic [SW-1:0]   req_size,
    input  logic            req_dir,
    input  logic [BW-1:0]   req_buf,
    output logic            bus_req,
    output logic [AW-1:0]   bus_addr,
    output logic [SW-1:0]   bus_size,
    output logic            bus_dir,
    input  logic            bus_done,
    input  logic            bus_err,
    output logic            retry_stb,
    output logic            xfer_ok,
    output logic            xfer_fail,
    output logic            irq,
    input  logic            irq_ack,
    output logic [NBUF-1:0] susp
);

    verdict_e        vd;
    logic            has_budget;
    logic [BW-1:0]   cur_buf;
    logic [NBUF-1:0] susp_w;

    rtry_budget #(.CW(CW)) u_budget (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr),
        .wr_data (cfg_wdata),
        .dec     (vd == VD_RETRY),
        .cnt     (cfg_rdata),
        .nz      (has_budget)
    );

    rtry_seq #(.AW(AW), .SW(SW), .NBUF(NBUF), .BW(BW)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_size   (req_size),
        .req_dir    (req_dir),
        .req_buf    (req_buf),
        .req_ready  (req_ready),
        .susp       (susp_w),
        .has_budget (has_budget),
        .bus_done   (bus_done),
        .bus_err    (bus_err),
        .bus_req    (bus_req),
        .bus_addr   (bus_addr),
        .bus_size   (bus_size),
        .bus_dir    (bus_dir),
        .retry_stb  (retry_stb),
        .verdict    (vd),
        .cur_buf    (cur_buf)
    );

    rtry_escal #(.NBUF(NBUF), .BW(BW)) u_escal (
        .clk     (clk),
        .rst     (rst),
        .esc     (vd == VD_ESCAL),
        .esc_buf (cur_buf),
        .ack     (irq_ack),
        .irq     (irq),
        .susp    (susp_w)
    );

    assign susp      = susp_w;
    assign xfer_ok   = (vd == VD_OK);
    assign xfer_fail = (vd == VD_ESCAL);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_req |-> (!xfer_ok && !xfer_fail));

    // R1
    reset_chk: assert property (@(posedge clk)
        $past(rst) |-> (cfg_rdata == '0 && !irq && susp == '0 && !bus_req && !retry_stb));

endmodule

// File: tb/sim_rtry_ctrl.sv
module sim_rtry_ctrl;

    localparam int AW = 32;
    localparam int SW = 2;
    localparam int CW = 8;
    localparam int NB = 2;
    localparam int BW = 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_wr = 1'b0;
    logic [CW-1:0] cfg_wdata = '0;
    logic [CW-1:0] cfg_rdata;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [SW-1:0] req_size = '0;
    logic          req_dir = 1'b0;
    logic [BW-1:0] req_buf = '0;
    logic          bus_req;
    logic [AW-1:0] bus_addr;
    logic [SW-1:0] bus_size;
    logic          bus_dir;
    logic          bus_done = 1'b0;
    logic          bus_err = 1'b0;
    logic          retry_stb;
    logic          xfer_ok;
    logic          xfer_fail;
    logic          irq;
    logic          irq_ack = 1'b0;
    logic [NB-1:0] susp;

    int checks = 0;
    int errors = 0;
    int model  = 0;
    bit escalated;

    always #10 clk = ~clk;

    rtry_ctrl #(.AW(AW), .SW(SW), .CW(CW), .NBUF(NB)) u0 (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .req_dir(req_dir),
        .req_buf(req_buf), .bus_req(bus_req), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_dir(bus_dir), .bus_done(bus_done),
        .bus_err(bus_err), .retry_stb(retry_stb), .xfer_ok(xfer_ok),
        .xfer_fail(xfer_fail), .irq(irq), .irq_ack(irq_ack), .susp(susp)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_budget(input int v);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wdata = CW'(v);
        @(negedge clk);
        cfg_wr = 1'b0;
        #1 chk("R2 budget readback", cfg_rdata, v);
    endtask

    // One bus cycle that fails nerr times before succeeding.
    task automatic xfer(input logic [AW-1:0] a, input logic [SW-1:0] s,
                        input logic d, input int b, input int nerr);
        int k = 0;
        bit fin = 0;
        escalated = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr = a; req_size = s; req_dir = d; req_buf = BW'(b);
        #1 chk("R7 ready for free buffer", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        while (!fin) begin
            #1;
            chk("R3 bus_req in issue", bus_req, 1);
            chk("R3 addr", bus_addr, a);
            chk("R3 size", bus_size, s);
            chk("R3 dir", bus_dir, d);
            chk("R3 retry_stb", retry_stb, (k > 0) ? 1 : 0);
            bus_done = 1'b1;
            bus_err  = (k < nerr);
            #1;
            if (k >= nerr) begin
                chk("R5 xfer_ok", xfer_ok, 1);
                @(negedge clk);
                bus_done = 1'b0; bus_err = 1'b0;
                #1 chk("R5 budget kept", cfg_rdata, model);
                fin = 1;
            end else if (model > 0) begin
                chk("R3 no fail pulse on retry", xfer_fail, 0);
                @(negedge clk);
                bus_done = 1'b0; bus_err = 1'b0;
                model--;
                #1;
                chk("R3 idle gap", bus_req, 0);
                chk("R3 budget decremented", cfg_rdata, model);
                @(negedge clk);
                k++;
            end else begin
                chk("R4 xfer_fail", xfer_fail, 1);
                @(negedge clk);
                bus_done = 1'b0; bus_err = 1'b0;
                #1;
                chk("R4 irq", irq, 1);
                chk("R4 susp bit", susp[b], 1);
                chk("R4 no reissue", bus_req, 0);
                escalated = 1;
                fin = 1;
            end
        end
    endtask

    task automatic do_ack();
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        #1;
        chk("R8 irq cleared", irq, 0);
        chk("R8 susp cleared", susp, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 budget", cfg_rdata, 0);
        chk("R1 irq", irq, 0);
        chk("R1 susp", susp, 0);
        chk("R1 bus_req", bus_req, 0);
        chk("R1 retry_stb", retry_stb, 0);

        wr_budget(8'hA7);
        wr_budget(8'hFF);

        // R10: sweep budget b and consecutive errors e
        for (int b = 0; b < 4; b++) begin
            for (int e = 0; e < 5; e++) begin
                int bf = (b + e) % 2;
                wr_budget(b);
                model = b;
                xfer(AW'(32'h1000_0000 + b * 256 + e * 4), SW'(e % 4), 1'(b % 2), bf, e);
                chk("R10 escalation outcome", escalated, (e > b) ? 1 : 0);
                chk("R10 remaining budget", cfg_rdata, (e > b) ? 0 : b - e);
                if (escalated) begin
                    req_buf = BW'(bf);
                    #1 chk("R7 blocked buffer", req_ready, 0);
                    req_buf = BW'(1 - bf);
                    #1 chk("R7 other buffer", req_ready, 1);
                    do_ack();
                    req_buf = BW'(bf);
                    #1 chk("R7 released after ack", req_ready, 1);
                end
            end
        end

        // R6: write collides with a retry decrement
        wr_budget(2);
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'hCAFE_0010; req_size = 2'd2; req_dir = 1'b1; req_buf = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        bus_done = 1'b1; bus_err = 1'b1;
        cfg_wr = 1'b1; cfg_wdata = 8'h55;
        @(negedge clk);
        bus_done = 1'b0; bus_err = 1'b0; cfg_wr = 1'b0;
        #1;
        chk("R6 write wins", cfg_rdata, 8'h55);
        chk("R6 gap still taken", bus_req, 0);
        @(negedge clk);
        #1;
        chk("R6 retry issued", retry_stb, 1);
        chk("R6 retry addr", bus_addr, 32'hCAFE_0010);
        bus_done = 1'b1;
        #1 chk("R6 retry ok", xfer_ok, 1);
        @(negedge clk);
        bus_done = 1'b0;
        #1 chk("R6 budget after success", cfg_rdata, 8'h55);

        // R9: stray completion with nothing outstanding
        @(negedge clk);
        bus_done = 1'b1; bus_err = 1'b1;
        #1;
        chk("R9 no fail pulse", xfer_fail, 0);
        chk("R9 no ok pulse", xfer_ok, 0);
        @(negedge clk);
        bus_done = 1'b0; bus_err = 1'b0;
        #1;
        chk("R9 budget unchanged", cfg_rdata, 8'h55);
        chk("R9 irq unchanged", irq, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule